// File: doc/BRIEF.md
# I2C Slave Address Matcher with Clock Stretching

This block is the slave-side address engine of a register-programmed I2C controller. It samples the raw SCL and SDA lines through a synchronizer chain and detects START and STOP conditions. After each START it shifts in the address byte, most significant bit first. It compares that byte against a programmable slave address in either 7-bit or 10-bit form. On a match it pulls SDA low for the acknowledge clock.

Once the last address byte has been acknowledged, the block raises an addressed-as-slave flag. It then holds SCL low until software writes the transmit buffer, so the bus master waits while the request is serviced. A detected STOP raises a separate status flag, which a status-register read clears. Each flag has its own enable for the single interrupt output. Both bus outputs are open-drain pull-down requests: a high output means "drive the line low".

Top module: `i2c_addr_slave`

## Requirements
- R1: While `cfg_enable` is low, the block drives neither line, detects no START or STOP, and holds both status flags at 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Address bits are collected only after a START. A STOP abandons any reception in progress.
- R3: In 7-bit mode, bits 7:1 of the first byte after a START are compared with `cfg_own_addr[6:0]`; bit 0 is R/W and `cfg_own_addr[9:7]` is ignored. On a match the block drives SDA low for the whole ninth SCL high period. On a mismatch SDA is left released.
- R4: In 10-bit mode the first byte must be `11110`, then `cfg_own_addr[9:8]`, then R/W. A write header that matches is acknowledged, and the next byte must equal `cfg_own_addr[7:0]`. The addressed flag is not set after the header acknowledge; it is set only after the second byte's acknowledge.
- R5: A 10-bit read header that follows a repeated START, after a fully matched 10-bit write address with no STOP in between, is acknowledged. The addressed flag is set after that single byte's acknowledge.
- R6: A 10-bit read header with no preceding matched write address since the last STOP is not acknowledged.
- R7: The addressed flag `stat_addressed` is set on the SCL falling edge that ends the final address acknowledge. While it is set, `scl_drive_low` is high.
- R8: A one-cycle pulse on `txbuf_wr` clears the addressed flag and releases SCL.
- R9: A detected STOP sets `stat_stop`. A pulse on `status_rd` clears it.
- R10: `irq_out` is high exactly when (`stat_addressed` and `cfg_irq_en_addr`) or (`stat_stop` and `cfg_irq_en_stop`).
- R11: In 10-bit mode, a second address byte that mismatches is not acknowledged and sets no flag. It also cancels the eligibility for the one-byte read of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_drive_low | output | 1 | Request to pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Request to pull SDA low (acknowledge) |
| cfg_enable | input | 1 | I2C mode enable |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_own_addr | input | 10 | Programmed slave address |
| cfg_irq_en_addr | input | 1 | Interrupt enable for the addressed flag |
| cfg_irq_en_stop | input | 1 | Interrupt enable for the STOP flag |
| txbuf_wr | input | 1 | Transmit-buffer write strobe |
| status_rd | input | 1 | Status-register read strobe |
| stat_addressed | output | 1 | Addressed-as-slave flag |
| stat_stop | output | 1 | STOP-detected flag |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default of 2. It drives a bus half period of ten clocks, so the deeper synchronizer latency still falls well inside each SCL low phase. This shows that the acknowledge drive and the stretch begin while SCL is low, whatever the chain depth. The programmed addresses have bits set outside the compared field, so any leak of the unused high bits into the 7-bit comparison shows up as a wrong acknowledge. The 10-bit runs chain a write header, a second byte and a repeated-START read. Together they reach the arming state behind the one-byte read path and its cancellation.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int ADDR_W   = 10;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam int PREFIX_W = 5;
  localparam logic [PREFIX_W-1:0] TEN_BIT_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    SLV_IDLE,
    SLV_RECV,
    SLV_ACK,
    SLV_SKIP
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = enable & scl_s & ~scl_q;
  assign scl_fall  = enable & ~scl_s & scl_q;
  // SDA edges count only while SCL stayed high across both samples
  assign start_det = enable & scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = enable & scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ten_bit,
  input  logic              second_byte,
  input  logic              armed,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit,
  output logic              is_final
);
  logic header_ok;

  always_comb begin
    header_ok = (rx_byte[BYTE_W-1 -: PREFIX_W] == TEN_BIT_PREFIX) &&
                (rx_byte[2:1] == own_addr[ADDR_W-1 -: 2]);
    hit      = 1'b0;
    is_final = 1'b1;
    if (!ten_bit) begin
      hit = (rx_byte[BYTE_W-1:1] == own_addr[6:0]);
    end else if (second_byte) begin
      hit = (rx_byte == own_addr[BYTE_W-1:0]);
    end else if (!rx_byte[0]) begin
      hit      = header_ok;
      is_final = 1'b0;
    end else begin
      hit = header_ok & armed;
    end
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              hit,
  input  logic              is_final,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              second_byte,
  output logic              armed,
  output logic              sda_low,
  output logic              addr_set
);
  slv_state_t       state;
  logic [CNT_W-1:0] bit_cnt;
  logic             ack_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SLV_IDLE;
      bit_cnt     <= '0;
      rx_byte     <= '0;
      second_byte <= 1'b0;
      armed       <= 1'b0;
      sda_low     <= 1'b0;
      ack_final   <= 1'b0;
      addr_set    <= 1'b0;
    end else if (!enable) begin
      state       <= SLV_IDLE;
      bit_cnt     <= '0;
      second_byte <= 1'b0;
      armed       <= 1'b0;
      sda_low     <= 1'b0;
      addr_set    <= 1'b0;
    end else begin
      addr_set <= 1'b0;
      if (stop_det) begin
        state       <= SLV_IDLE;
        second_byte <= 1'b0;
        armed       <= 1'b0;
        sda_low     <= 1'b0;
      end else if (start_det) begin
        state       <= SLV_RECV;
        bit_cnt     <= '0;
        second_byte <= 1'b0;
        sda_low     <= 1'b0;
      end else begin
        unique case (state)
          SLV_RECV: begin
            if (scl_rise) begin
              rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
              if (hit) begin
                state     <= SLV_ACK;
                sda_low   <= 1'b1;
                ack_final <= is_final;
                if (second_byte) armed <= 1'b1;
              end else begin
                state <= SLV_SKIP;
                if (second_byte) armed <= 1'b0;
              end
            end
          end
          SLV_ACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              if (ack_final) begin
                state    <= SLV_SKIP;
                addr_set <= 1'b1;
              end else begin
                state       <= SLV_RECV;
                bit_cnt     <= '0;
                second_byte <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic addr_set,
  input  logic stop_det,
  input  logic txbuf_wr,
  input  logic status_rd,
  input  logic irq_en_addr,
  input  logic irq_en_stop,
  output logic addr_flag,
  output logic stop_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_flag <= 1'b0;
      stop_flag <= 1'b0;
    end else if (!enable) begin
      addr_flag <= 1'b0;
      stop_flag <= 1'b0;
    end else begin
      if (addr_set)      addr_flag <= 1'b1;
      else if (txbuf_wr) addr_flag <= 1'b0;
      if (stop_det)       stop_flag <= 1'b1;
      else if (status_rd) stop_flag <= 1'b0;
    end
  end

  assign irq = (addr_flag & irq_en_addr) | (stop_flag & irq_en_stop);
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              cfg_enable,
  input  logic              cfg_ten_bit,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_irq_en_addr,
  input  logic              cfg_irq_en_stop,
  input  logic              txbuf_wr,
  input  logic              status_rd,
  output logic              stat_addressed,
  output logic              stat_stop,
  output logic              irq_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic second_byte, armed, hit, is_final, addr_set;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_addr_match u_match (
    .rx_byte     (rx_byte),
    .ten_bit     (cfg_ten_bit),
    .second_byte (second_byte),
    .armed       (armed),
    .own_addr    (cfg_own_addr),
    .hit         (hit),
    .is_final    (is_final)
  );

  i2c_slave_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .sda_s       (sda_s),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .hit         (hit),
    .is_final    (is_final),
    .rx_byte     (rx_byte),
    .second_byte (second_byte),
    .armed       (armed),
    .sda_low     (sda_drive_low),
    .addr_set    (addr_set)
  );

  i2c_status_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .addr_set    (addr_set),
    .stop_det    (stop_det),
    .txbuf_wr    (txbuf_wr),
    .status_rd   (status_rd),
    .irq_en_addr (cfg_irq_en_addr),
    .irq_en_stop (cfg_irq_en_stop),
    .addr_flag   (stat_addressed),
    .stop_flag   (stat_stop),
    .irq         (irq_out)
  );

  assign scl_drive_low = stat_addressed;
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic scl_s,
  input logic stop_det,
  input logic txbuf_wr,
  input logic status_rd,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic stat_addressed,
  input logic stat_stop,
  input logic irq_out
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!stat_addressed && !stat_stop && !sda_drive_low && !scl_drive_low));

  assert_ack_starts_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  assert_stretch_starts_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_addressed) |-> !scl_s);

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_addressed && txbuf_wr) |=> (!stat_addressed && !scl_drive_low));

  assert_stop_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> stat_stop);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_stop && status_rd && !stop_det) |=> !stat_stop);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (stat_addressed || stat_stop));
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_enable     (cfg_enable),
  .scl_s          (scl_s),
  .stop_det       (stop_det),
  .txbuf_wr       (txbuf_wr),
  .status_rd      (status_rd),
  .scl_drive_low  (scl_drive_low),
  .sda_drive_low  (sda_drive_low),
  .stat_addressed (stat_addressed),
  .stat_stop      (stat_stop),
  .irq_out        (irq_out)
);

// File: tb/test_i2c_addr_slave.sv
module test_i2c_addr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_drive_low, sda_drive_low;
  logic cfg_enable = 1'b1, cfg_ten_bit = 1'b0;
  logic [9:0] cfg_own_addr = 10'h3A5;
  logic cfg_irq_en_addr = 1'b1, cfg_irq_en_stop = 1'b1;
  logic txbuf_wr = 1'b0, status_rd = 1'b0;
  logic stat_addressed, stat_stop, irq_out;
  logic scl_bus, sda_bus;

  int n_tests = 0;
  int n_fail = 0;

  typedef struct {
    logic  ack;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  event ack_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_bus = scl_m & ~scl_drive_low;
  assign sda_bus = sda_m & ~sda_drive_low;

  i2c_addr_slave #(.SYNC_STAGES(3)) i_i2c_addr_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_in          (scl_bus),
    .sda_in          (sda_bus),
    .scl_drive_low   (scl_drive_low),
    .sda_drive_low   (sda_drive_low),
    .cfg_enable      (cfg_enable),
    .cfg_ten_bit     (cfg_ten_bit),
    .cfg_own_addr    (cfg_own_addr),
    .cfg_irq_en_addr (cfg_irq_en_addr),
    .cfg_irq_en_stop (cfg_irq_en_stop),
    .txbuf_wr        (txbuf_wr),
    .status_rd       (status_rd),
    .stat_addressed  (stat_addressed),
    .stat_stop       (stat_stop),
    .irq_out         (irq_out)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; idle(H);
    scl_m = 1'b0; idle(H);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; idle(H);
    scl_m = 1'b1; wait_scl_high(); idle(H);
    sda_m = 1'b0; idle(H);
    scl_m = 1'b0; idle(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(H);
    scl_m = 1'b1; wait_scl_high(); idle(H);
    sda_m = 1'b1; idle(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; idle(H);
    scl_m = 1'b1; wait_scl_high(); idle(H);
    scl_m = 1'b0;
  endtask

  // driver: pushes the expected acknowledge, then clocks the ninth bit
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    exp_t e;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    e.ack = exp_ack;
    e.tag = tag;
    exp_q.push_back(e);
    sda_m = 1'b1; idle(H);
    scl_m = 1'b1; wait_scl_high(); idle(H/2);
    -> ack_slot;
    idle(H/2);
    scl_m = 1'b0; idle(H);
  endtask

  task automatic pulse_tx();
    txbuf_wr = 1'b1; idle(1);
    txbuf_wr = 1'b0; idle(2);
  endtask

  task automatic pulse_rd();
    status_rd = 1'b1; idle(1);
    status_rd = 1'b0; idle(2);
  endtask

  // monitor: compares each acknowledge slot against the scoreboard
  initial begin
    forever begin
      exp_t e;
      @(ack_slot);
      if (exp_q.size() == 0) begin
        chk("R3", "unexpected ack slot", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(e.tag, "ack on SDA", int'(sda_bus == 1'b0), int'(e.ack));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    chk("R7", "reset addressed flag", stat_addressed, 0);
    chk("R9", "reset stop flag", stat_stop, 0);
    chk("R7", "reset scl drive", scl_drive_low, 0);
    chk("R10", "reset irq", irq_out, 0);

    // 7-bit write match, stretch, release, STOP
    bus_start();
    send_byte({7'h25, 1'b0}, 1'b1, "R3");
    chk("R7", "flag after ack", stat_addressed, 1);
    chk("R7", "scl stretched", scl_drive_low, 1);
    chk("R10", "irq on addressed", irq_out, 1);
    idle(30);
    chk("R7", "stretch held", scl_drive_low, 1);
    pulse_tx();
    chk("R8", "flag cleared by tx write", stat_addressed, 0);
    chk("R8", "scl released", scl_drive_low, 0);
    chk("R10", "irq low after clear", irq_out, 0);
    bus_stop();
    chk("R9", "stop flag set", stat_stop, 1);
    chk("R10", "irq on stop", irq_out, 1);
    pulse_rd();
    chk("R9", "stop flag cleared by read", stat_stop, 0);

    // 7-bit mismatch
    bus_start();
    send_byte({7'h26, 1'b0}, 1'b0, "R3");
    chk("R3", "no flag on mismatch", stat_addressed, 0);
    chk("R3", "no stretch on mismatch", scl_drive_low, 0);
    bus_stop(); pulse_rd();

    // 7-bit read match
    bus_start();
    send_byte({7'h25, 1'b1}, 1'b1, "R3");
    chk("R7", "flag after read ack", stat_addressed, 1);
    pulse_tx(); bus_stop(); pulse_rd();

    // interrupt masking
    cfg_irq_en_addr = 1'b0;
    cfg_irq_en_stop = 1'b0;
    bus_start();
    send_byte({7'h25, 1'b0}, 1'b1, "R3");
    chk("R10", "masked flag set", stat_addressed, 1);
    chk("R10", "masked irq", irq_out, 0);
    pulse_tx(); bus_stop();
    chk("R10", "masked stop flag set", stat_stop, 1);
    chk("R10", "masked stop irq", irq_out, 0);
    pulse_rd();
    cfg_irq_en_addr = 1'b1;
    cfg_irq_en_stop = 1'b1;

    // disabled block
    cfg_enable = 1'b0;
    bus_start();
    send_byte({7'h25, 1'b0}, 1'b0, "R1");
    chk("R1", "no flag while disabled", stat_addressed, 0);
    chk("R1", "no stretch while disabled", scl_drive_low, 0);
    bus_stop();
    chk("R1", "no stop flag while disabled", stat_stop, 0);
    cfg_enable = 1'b1;
    idle(3);

    // STOP abandons reception; bits without START are ignored
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); pulse_rd();
    sda_m = 1'b1; scl_m = 1'b0; idle(H);
    send_byte({7'h25, 1'b0}, 1'b0, "R2");
    chk("R2", "no flag without START", stat_addressed, 0);
    bus_stop(); pulse_rd();

    // 10-bit addressing: own = 10'h2C7
    cfg_ten_bit  = 1'b1;
    cfg_own_addr = 10'h2C7;
    bus_start();
    send_byte(8'hF4, 1'b1, "R4");
    chk("R4", "no flag after header", stat_addressed, 0);
    send_byte(8'hC7, 1'b1, "R4");
    chk("R4", "flag after second byte", stat_addressed, 1);
    pulse_tx();
    bus_rstart();
    send_byte(8'hF5, 1'b1, "R5");
    chk("R5", "flag after one-byte read", stat_addressed, 1);
    pulse_tx(); bus_stop(); pulse_rd();

    // read header without prior match
    bus_start();
    send_byte(8'hF5, 1'b0, "R6");
    chk("R6", "no flag on unarmed read", stat_addressed, 0);
    bus_stop(); pulse_rd();

    // second byte mismatch cancels arming
    bus_start();
    send_byte(8'hF4, 1'b1, "R11");
    send_byte(8'hC6, 1'b0, "R11");
    chk("R11", "no flag on second mismatch", stat_addressed, 0);
    bus_rstart();
    send_byte(8'hF5, 1'b0, "R11");
    bus_stop(); pulse_rd();

    // wrong upper address bits in header
    bus_start();
    send_byte(8'hF6, 1'b0, "R4");
    bus_stop(); pulse_rd();

    idle(5);
    chk("R3", "pending ack slots", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule